// File: doc/BRIEF.md
# Security-State Memory Access Firewall

The firewall sits between one requester and a downstream memory or peripheral port. Each request carries the world the requester currently runs in, an address, and the non-secure (NS) flag taken from its translation descriptor. The firewall works out the NS attribute the request actually leaves with. A normal-world requester can only ever issue non-secure accesses. A secure-world requester picks either kind through its descriptor flag.

The address is compared against a small file of programmable regions. Each region has a base, an inclusive limit, an enable bit and a secure-only bit. A non-secure access that lands in an enabled secure-only region is refused. The refused request never reaches the downstream port. It completes at once with an error flag and all-zero read data. Every other request passes straight through, with the same handshake and the same data.

The region file is programmed over a small configuration port. Each write on that port is tagged with its own security attribute. Only secure writes change state. A non-secure write is dropped and answered with an error. After reset every region is disabled, so everything is reachable until secure software sets the regions up.

Top module: `sec_access_firewall`

## Requirements
- R1: A request from the normal world (`req_world_secure`=0) leaves with `dn_ns`=1, whatever `req_desc_ns` is.
- R2: A request from the secure world (`req_world_secure`=1) leaves with `dn_ns` equal to `req_desc_ns`.
- R3: A region matches when it is enabled and secure-only and base <= addr <= limit, with both ends inclusive. A request whose outgoing NS is 1 and that matches any region is refused in the same cycle: `rsp_err`=1, `rsp_rdata`=0, `req_ready`=1 and `dn_valid`=0.
- R4: A secure access (outgoing NS=0) to a secure-only region is forwarded without error.
- R5: A refused write never asserts `dn_valid`.
- R6: An accepted request is passed through combinationally: `dn_valid`=`req_valid`, `req_ready`=`dn_ready`, `rsp_rdata`=`dn_rdata` and `rsp_err`=0.
- R7: A configuration write with `cfg_secure`=1 updates the selected field at the next clock edge and gives `cfg_err`=0. Field codes on `cfg_field`: 0 = base, 1 = limit, 2 = control (bit0 = enable, bit1 = secure-only). `cfg_rdata` always returns the field selected by `cfg_idx`/`cfg_field`, and code 3 reads as 0.
- R8: A configuration write with `cfg_secure`=0 gives `cfg_err`=1 in the same cycle and leaves every register unchanged.
- R9: After reset all region fields read 0, all regions are disabled and every request is forwarded.
- R10: A region that is enabled but not secure-only never refuses a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted or refused this cycle |
| req_world_secure | input | 1 | Requester world: 1 = secure, 0 = normal |
| req_desc_ns | input | 1 | NS flag from the translation descriptor |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| rsp_err | output | 1 | Error response for a refused request |
| rsp_rdata | output | 32 | Read data (zero when refused) |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream ready |
| dn_ns | output | 1 | Final NS attribute |
| dn_write | output | 1 | Downstream write flag |
| dn_addr | output | 32 | Downstream address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_secure | input | 1 | Security attribute of the configuration access |
| cfg_idx | input | 2 | Region index |
| cfg_field | input | 2 | Field code (0 base, 1 limit, 2 control) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected field value |
| cfg_err | output | 1 | Configuration write refused |

## Verification
Requests are driven from both worlds with both descriptor flag values. This separates the forcing rule of the normal world from the pass-through rule of the secure world. Addresses are placed on the first and last word of a secure-only region and one word outside each end, which shows whether the range compare is inclusive. The same address is then issued as a secure access, a non-secure access from the secure world, a write and a read, to tell the NS-based decision apart from a plain address match. The configuration registers are read back after secure and non-secure writes, and a region that is enabled but not secure-only is exercised. A stalled downstream port shows that the handshake passes through only on accepted requests.

// File: rtl/fw_pkg.sv
package fw_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;

    localparam logic [1:0] FLD_BASE  = 2'd0;
    localparam logic [1:0] FLD_LIMIT = 2'd1;
    localparam logic [1:0] FLD_CTRL  = 2'd2;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic              en;
        logic              sec_only;
    } region_t;

    function automatic logic in_window(input region_t r, input logic [ADDR_W-1:0] a);
        return r.en && r.sec_only && (a >= r.base) && (a <= r.limit);
    endfunction
endpackage

// File: rtl/fw_attr_gen.sv
module fw_attr_gen (
    input  logic world_secure,
    input  logic desc_ns,
    output logic final_ns
);
    always_comb begin
        if (world_secure) final_ns = desc_ns;
        else              final_ns = 1'b1;
    end
endmodule

// File: rtl/fw_region_file.sv
module fw_region_file
    import fw_pkg::*;
#(
    parameter int NREG = 4,
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_secure,
    input  logic [IW-1:0]     cfg_idx,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              cfg_err,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic [NREG-1:0]   hit
);
    region_t regs [NREG];

    assign cfg_err = cfg_we && !cfg_secure;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (cfg_we && cfg_secure && (cfg_idx == IW'(i))) begin
                case (cfg_field)
                    FLD_BASE:  regs[i].base  <= cfg_wdata;
                    FLD_LIMIT: regs[i].limit <= cfg_wdata;
                    FLD_CTRL: begin
                        regs[i].en       <= cfg_wdata[0];
                        regs[i].sec_only <= cfg_wdata[1];
                    end
                    default: ;
                endcase
            end
        end
        assign hit[i] = in_window(regs[i], probe_addr);
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_field)
            FLD_BASE:  cfg_rdata = regs[cfg_idx].base;
            FLD_LIMIT: cfg_rdata = regs[cfg_idx].limit;
            FLD_CTRL:  cfg_rdata = {{(ADDR_W-2){1'b0}}, regs[cfg_idx].sec_only, regs[cfg_idx].en};
            default:   cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fw_filter.sv
module fw_filter
    import fw_pkg::*;
#(
    parameter int NREG = 4
) (
    input  logic              req_valid,
    input  logic              final_ns,
    input  logic [NREG-1:0]   hit,
    input  logic              dn_ready,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic              dn_valid,
    output logic              req_ready,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic refuse;

    always_comb begin
        refuse    = final_ns && (|hit);
        dn_valid  = req_valid && !refuse;
        req_ready = refuse ? 1'b1 : dn_ready;
        rsp_err   = req_valid && refuse;
        rsp_rdata = refuse ? '0 : dn_rdata;
    end
endmodule

// File: rtl/sec_access_firewall.sv
module sec_access_firewall
    import fw_pkg::*;
#(
    parameter int NREG = 4,
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_world_secure,
    input  logic              req_desc_ns,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_ns,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              cfg_we,
    input  logic              cfg_secure,
    input  logic [IW-1:0]     cfg_idx,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              cfg_err
);
    logic            final_ns;
    logic [NREG-1:0] hit;

    fw_attr_gen u_attr (
        .world_secure (req_world_secure),
        .desc_ns      (req_desc_ns),
        .final_ns     (final_ns)
    );

    fw_region_file #(.NREG(NREG)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_secure (cfg_secure),
        .cfg_idx    (cfg_idx),
        .cfg_field  (cfg_field),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_err    (cfg_err),
        .probe_addr (req_addr),
        .hit        (hit)
    );

    fw_filter #(.NREG(NREG)) u_filt (
        .req_valid (req_valid),
        .final_ns  (final_ns),
        .hit       (hit),
        .dn_ready  (dn_ready),
        .dn_rdata  (dn_rdata),
        .dn_valid  (dn_valid),
        .req_ready (req_ready),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    assign dn_ns    = final_ns;
    assign dn_write = req_write;
    assign dn_addr  = req_addr;
    assign dn_wdata = req_wdata;
endmodule

// File: rtl/fw_checker.sv
module fw_checker
    import fw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_world_secure,
    input logic              req_desc_ns,
    input logic              req_write,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic              dn_ns,
    input logic              cfg_we,
    input logic              cfg_secure,
    input logic              cfg_err
);
    // R1
    normal_forced_ns_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_world_secure) |-> dn_ns);

    // R2
    secure_follows_desc_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_world_secure) |-> (dn_ns == req_desc_ns));

    // R3
    refused_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == '0 && req_ready && dn_ns));

    // R5
    refused_write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && rsp_err) |-> !dn_valid);

    // R6
    accepted_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_err) |-> (dn_valid && (req_ready == dn_ready)));

    // R8
    nonsec_cfg_err_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_secure) |-> cfg_err);

    // R7
    sec_cfg_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_secure) |-> !cfg_err);
endmodule

bind sec_access_firewall fw_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .req_world_secure (req_world_secure),
    .req_desc_ns      (req_desc_ns),
    .req_write        (req_write),
    .rsp_err          (rsp_err),
    .rsp_rdata        (rsp_rdata),
    .dn_valid         (dn_valid),
    .dn_ready         (dn_ready),
    .dn_ns            (dn_ns),
    .cfg_we           (cfg_we),
    .cfg_secure       (cfg_secure),
    .cfg_err          (cfg_err)
);

// File: tb/sim_sec_access_firewall.sv
`timescale 1ns/100ps
module sim_sec_access_firewall;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_world_secure = 0, req_desc_ns = 0, req_write = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic        req_ready, rsp_err, dn_valid, dn_ns, dn_write;
    logic [31:0] rsp_rdata, dn_addr, dn_wdata, cfg_rdata;
    logic        dn_ready = 1;
    logic [31:0] dn_rdata = 0;
    logic        cfg_we = 0, cfg_secure = 0;
    logic [1:0]  cfg_idx = 0, cfg_field = 0;
    logic [31:0] cfg_wdata = 0;
    logic        cfg_err;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic        v;
        logic        ns;
        logic        err;
        logic        rdy;
        logic [31:0] rd;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    logic [31:0] m_base [4];
    logic [31:0] m_limit[4];
    logic        m_en   [4];
    logic        m_sec  [4];

    always #2.5 clk = ~clk;

    sec_access_firewall u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_world_secure(req_world_secure), .req_desc_ns(req_desc_ns),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_ns(dn_ns),
        .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_rdata(dn_rdata),
        .cfg_we(cfg_we), .cfg_secure(cfg_secure), .cfg_idx(cfg_idx),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic model_hit(input logic [31:0] a);
        logic h = 1'b0;
        for (int i = 0; i < 4; i++)
            if (m_en[i] && m_sec[i] && a >= m_base[i] && a <= m_limit[i]) h = 1'b1;
        return h;
    endfunction

    task automatic access(input string tag, input logic world, input logic dns,
                          input logic wr, input logic [31:0] a, input logic rdy);
        exp_t  e;
        logic  blk;
        @(posedge clk); #1;
        req_valid = 1; req_world_secure = world; req_desc_ns = dns;
        req_write = wr; req_addr = a; req_wdata = ~a;
        dn_ready = rdy; dn_rdata = a ^ 32'hA5A5_0000;
        e.ns  = world ? dns : 1'b1;
        blk   = e.ns && model_hit(a);
        e.v   = !blk;
        e.err = blk;
        e.rdy = blk ? 1'b1 : rdy;
        e.rd  = blk ? 32'h0 : (a ^ 32'hA5A5_0000);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " dn_valid"}, {31'b0, dn_valid}, {31'b0, e.v});
            check({t, " rsp_err"}, {31'b0, rsp_err}, {31'b0, e.err});
            check({t, " req_ready"}, {31'b0, req_ready}, {31'b0, e.rdy});
            check({t, " rsp_rdata"}, rsp_rdata, e.rd);
            if (e.v) check({t, " dn_ns"}, {31'b0, dn_ns}, {31'b0, e.ns});
        end
    end

    task automatic cfg_write(input string tag, input logic sec, input logic [1:0] idx,
                             input logic [1:0] fld, input logic [31:0] d);
        @(posedge clk); #1;
        req_valid = 0;
        cfg_we = 1; cfg_secure = sec; cfg_idx = idx; cfg_field = fld; cfg_wdata = d;
        #1 check({tag, " cfg_err"}, {31'b0, cfg_err}, {31'b0, !sec});
        if (sec) begin
            if (fld == 2'd0) m_base[idx] = d;
            if (fld == 2'd1) m_limit[idx] = d;
            if (fld == 2'd2) begin m_en[idx] = d[0]; m_sec[idx] = d[1]; end
        end
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic cfg_read(input string tag, input logic [1:0] idx, input logic [1:0] fld,
                            input logic [31:0] expv);
        @(posedge clk); #1;
        req_valid = 0;
        cfg_idx = idx; cfg_field = fld;
        #1 check(tag, cfg_rdata, expv);
    endtask

    initial begin
        #150000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_base[i] = 0; m_limit[i] = 0; m_en[i] = 0; m_sec[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R9: reset state of the region file and open access
        cfg_read("R9 base0", 2'd0, 2'd0, 32'h0);
        cfg_read("R9 limit3", 2'd3, 2'd1, 32'h0);
        cfg_read("R9 ctrl1", 2'd1, 2'd2, 32'h0);
        access("R9 open read", 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1);
        // R1: normal world forced to NS=1
        access("R1 normal desc0", 1'b0, 1'b0, 1'b0, 32'h0000_0040, 1'b1);
        access("R1 normal desc1", 1'b0, 1'b1, 1'b1, 32'h0000_0080, 1'b1);
        // R2: secure world follows descriptor
        access("R2 secure desc0", 1'b1, 1'b0, 1'b0, 32'h0000_00C0, 1'b1);
        access("R2 secure desc1", 1'b1, 1'b1, 1'b0, 32'h0000_0100, 1'b1);

        // R7: program region 1 as secure-only 0x1000..0x1FFF
        cfg_write("R7 base", 1'b1, 2'd1, 2'd0, 32'h0000_1000);
        cfg_write("R7 limit", 1'b1, 2'd1, 2'd1, 32'h0000_1FFF);
        cfg_write("R7 ctrl", 1'b1, 2'd1, 2'd2, 32'h0000_0003);
        cfg_read("R7 base rb", 2'd1, 2'd0, 32'h0000_1000);
        cfg_read("R7 limit rb", 2'd1, 2'd1, 32'h0000_1FFF);
        cfg_read("R7 ctrl rb", 2'd1, 2'd2, 32'h0000_0003);
        cfg_read("R7 field3 zero", 2'd1, 2'd3, 32'h0);

        // R3: inclusive bounds
        access("R3 low edge", 1'b0, 1'b0, 1'b0, 32'h0000_1000, 1'b1);
        access("R3 high edge", 1'b0, 1'b0, 1'b0, 32'h0000_1FFF, 1'b1);
        access("R3 below", 1'b0, 1'b0, 1'b0, 32'h0000_0FFF, 1'b1);
        access("R3 above", 1'b0, 1'b0, 1'b0, 32'h0000_2000, 1'b1);
        access("R3 secure world ns desc", 1'b1, 1'b1, 1'b0, 32'h0000_1800, 1'b1);
        access("R3 refused ignores stall", 1'b0, 1'b0, 1'b0, 32'h0000_1200, 1'b0);
        // R5: refused write not forwarded
        access("R5 normal write", 1'b0, 1'b1, 1'b1, 32'h0000_1800, 1'b1);
        // R4: secure access to secure region
        access("R4 secure read", 1'b1, 1'b0, 1'b0, 32'h0000_1800, 1'b1);
        access("R4 secure write", 1'b1, 1'b0, 1'b1, 32'h0000_1FFF, 1'b1);

        // R8: non-secure config write ignored
        cfg_write("R8 ctrl", 1'b0, 2'd1, 2'd2, 32'h0000_0000);
        cfg_write("R8 base", 1'b0, 2'd1, 2'd0, 32'h0000_5000);
        cfg_read("R8 ctrl rb", 2'd1, 2'd2, 32'h0000_0003);
        cfg_read("R8 base rb", 2'd1, 2'd0, 32'h0000_1000);
        access("R8 still blocked", 1'b0, 1'b0, 1'b0, 32'h0000_1000, 1'b1);

        // R10: enabled but not secure-only
        cfg_write("R10 base", 1'b1, 2'd2, 2'd0, 32'h0000_3000);
        cfg_write("R10 limit", 1'b1, 2'd2, 2'd1, 32'h0000_3FFF);
        cfg_write("R10 ctrl", 1'b1, 2'd2, 2'd2, 32'h0000_0001);
        access("R10 normal in open region", 1'b0, 1'b0, 1'b0, 32'h0000_3800, 1'b1);

        // R6: downstream stall passed through
        access("R6 stall", 1'b0, 1'b0, 1'b0, 32'h0000_4000, 1'b0);
        access("R6 ready", 1'b1, 1'b1, 1'b1, 32'h0000_4004, 1'b1);

        @(posedge clk); #1 req_valid = 0;
        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule